// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional Next-Address Selection

This block is the sequencing core of a microcoded control unit. A micro-program counter addresses an internal control store. The word at that address is held in a microinstruction register, and the control-signal field of that register drives the rest of the machine. On every clock a combinational sequencer picks where the counter goes next. It looks at the branch-control bits of the held word and at the Zero and Sign flags. The four candidates are the counter plus one, the start address that an opcode-mapping table gives for the current opcode, an address supplied from outside, and the branch-target field of the held word.

A two-bit source code in each word names the candidate. A five-bit condition mask names the flag tests that allow the jump. When the source code is nonzero and any masked test is true, the named candidate is loaded. In every other case the counter falls through to the next address. A not-taken conditional jump to the opcode map or to the external address therefore continues in line, which makes dispatch, interrupt entry and test-and-loop idioms cheap to write. The control store and the opcode map are loaded through one write port, normally while reset is held. Flag generation and the datapath that consumes the control signals belong to other blocks.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the counter loads `extAddr` and the microinstruction register clears, so after that edge `upcOut` equals `extAddr` and `ctrlOut` is zero.
- R2: At the first edge after reset is released, the counter holds its value and the word at that address is loaded. `ctrlOut` then shows that word's control field and `upcOut` is unchanged.
- R3: A control word is `{ctrl[C-1:0], target[n-1:0], cond[4:0], src[1:0]}`, with `src` in bits 1:0, `cond` in bits 6:2, the branch target in bits 6+n:7 and the control signals in the top C bits. From then on, each edge loads the counter with the chosen next address and the register with the store word at that address, so `ctrlOut` always shows the control field of the word at `upcOut`.
- R4: A word with `src` = 00 always advances to `upcOut`+1, whatever its condition bits and the flags.
- R5: With a nonzero `src` and a true condition, the next address is taken from the opcode map at index `opcode` (01), from `extAddr` (10) or from the word's target field (11). The values used are those of the cycle in which the decision is made.
- R6: With a nonzero `src` and no true condition (including an all-zero mask), the next address is `upcOut`+1.
- R7: Condition bit 0 is always true. Bit 1 is true when Z=0, bit 2 when Z=1, bit 3 when N=0 and bit 4 when N=1. Several set bits combine as a logical OR.
- R8: Advancing from the highest address wraps to address 0.
- R9: A write with `wrSel`=0 stores `wrData` at `wrAddr` in the control store. A write with `wrSel`=1 stores `wrData[n-1:0]` in opcode-map entry `wrAddr[OPW-1:0]`.
- R10: A test word with zero control signals that jumps forward on N=0, followed by a word that jumps back unconditionally, forms a loop. The loop repeats while N=1 and exits to the forward target once N=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| extAddr | input | PC_W | External next address, also the reset address |
| opcode | input | OP_W | Opcode used to index the mapping table |
| zFlag | input | 1 | Zero flag |
| nFlag | input | 1 | Sign flag |
| wrEn | input | 1 | Write strobe for the store or the map |
| wrSel | input | 1 | Write target: 0 control store, 1 opcode map |
| wrAddr | input | PC_W | Write address |
| wrData | input | CTRL_W+PC_W+7 | Write data |
| ctrlOut | output | CTRL_W | Control-signal field of the microinstruction register |
| upcOut | output | PC_W | Current micro-program counter |

## Verification
Reset takes effect at the edge where `rst` is high, so the reset values are sampled at the falling edge that follows it. The priming edge after release keeps the counter still and fills the register one cycle later. After that, each next-address decision uses the flags, opcode and `extAddr` driven before a rising edge, and its result appears on `upcOut` and `ctrlOut` at the following falling edge. The bench drives every stimulus half a cycle ahead and predicts each step from its own copy of the store and map. It sweeps every combination of source code, condition mask and flag pair once, then walks the example routine through dispatch, external jump, forward branch and loop.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    SRC_INC = 2'b00,
    SRC_MAP = 2'b01,
    SRC_EXT = 2'b10,
    SRC_BR  = 2'b11
  } srcCode_t;

  localparam int COND_W = 5;
  localparam int SRC_W  = 2;

  // one-hot next-address strobes from sequencer to datapath
  typedef struct packed {
    logic holdPc;
    logic selInc;
    logic selMap;
    logic selExt;
    logic selBr;
  } seqStrobe_t;

endpackage

// File: rtl/useq_seqctl.sv
module useq_seqctl
  import useq_pkg::*;
(
  input  logic              primed,
  input  logic [SRC_W-1:0]  srcCode,
  input  logic [COND_W-1:0] condBits,
  input  logic              zFlag,
  input  logic              nFlag,
  output seqStrobe_t        strobes
);

  logic [COND_W-1:0] condVec;
  logic condTrue;
  logic taken;

  // bit0 always, bit1 Z=0, bit2 Z=1, bit3 N=0, bit4 N=1
  assign condVec  = {nFlag, ~nFlag, zFlag, ~zFlag, 1'b1};
  assign condTrue = |(condBits & condVec);
  assign taken    = (srcCode != SRC_INC) && condTrue;

  always_comb begin
    strobes = '0;
    if (!primed) begin
      strobes.holdPc = 1'b1;
    end else if (!taken) begin
      strobes.selInc = 1'b1;
    end else begin
      case (srcCode_t'(srcCode))
        SRC_MAP: strobes.selMap = 1'b1;
        SRC_EXT: strobes.selExt = 1'b1;
        SRC_BR:  strobes.selBr  = 1'b1;
        default: strobes.selInc = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/useq_datapath.sv
module useq_datapath
  import useq_pkg::*;
#(
  parameter int PC_W   = 9,
  parameter int CTRL_W = 16,
  parameter int OP_W   = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [PC_W-1:0]              extAddr,
  input  logic [OP_W-1:0]              opcode,
  input  logic                         wrEn,
  input  logic                         wrSel,
  input  logic [PC_W-1:0]              wrAddr,
  input  logic [CTRL_W+PC_W+COND_W+SRC_W-1:0] wrData,
  input  seqStrobe_t                   strobes,
  output logic [PC_W-1:0]              upc,
  output logic [CTRL_W-1:0]            ctrlField,
  output logic [SRC_W-1:0]             srcCode,
  output logic [COND_W-1:0]            condBits,
  output logic [PC_W-1:0]              brAddr,
  output logic                         primed
);

  localparam int WORD_W    = CTRL_W + PC_W + COND_W + SRC_W;
  localparam int DEPTH     = 1 << PC_W;
  localparam int MAP_DEPTH = 1 << OP_W;
  localparam int COND_LO   = SRC_W;
  localparam int BR_LO     = SRC_W + COND_W;
  localparam int CTRL_LO   = BR_LO + PC_W;

  logic [WORD_W-1:0] ctrlStore [DEPTH];
  logic [PC_W-1:0]   opMap [MAP_DEPTH];
  logic [WORD_W-1:0] uir;
  logic [PC_W-1:0]   nextPc;
  logic [PC_W-1:0]   incPc;

  assign incPc     = upc + 1'b1;
  assign srcCode   = uir[COND_LO-1:0];
  assign condBits  = uir[BR_LO-1:COND_LO];
  assign brAddr    = uir[CTRL_LO-1:BR_LO];
  assign ctrlField = uir[WORD_W-1:CTRL_LO];

  always_comb begin
    nextPc = incPc;
    if (strobes.holdPc)      nextPc = upc;
    else if (strobes.selMap) nextPc = opMap[opcode];
    else if (strobes.selExt) nextPc = extAddr;
    else if (strobes.selBr)  nextPc = brAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upc    <= extAddr;
      uir    <= '0;
      primed <= 1'b0;
    end else begin
      upc    <= nextPc;
      uir    <= ctrlStore[nextPc];
      primed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn && !wrSel) ctrlStore[wrAddr] <= wrData;
    if (wrEn && wrSel)  opMap[wrAddr[OP_W-1:0]] <= wrData[PC_W-1:0];
  end

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int PC_W   = 9,
  parameter int CTRL_W = 16,
  parameter int OP_W   = 6
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [PC_W-1:0]                    extAddr,
  input  logic [OP_W-1:0]                    opcode,
  input  logic                               zFlag,
  input  logic                               nFlag,
  input  logic                               wrEn,
  input  logic                               wrSel,
  input  logic [PC_W-1:0]                    wrAddr,
  input  logic [CTRL_W+PC_W+COND_W+SRC_W-1:0] wrData,
  output logic [CTRL_W-1:0]                  ctrlOut,
  output logic [PC_W-1:0]                    upcOut
);

  seqStrobe_t          strobes;
  logic [SRC_W-1:0]    srcCode;
  logic [COND_W-1:0]   condBits;
  logic [PC_W-1:0]     brAddr;
  logic                primed;

  useq_seqctl u_ctl (
    .primed   (primed),
    .srcCode  (srcCode),
    .condBits (condBits),
    .zFlag    (zFlag),
    .nFlag    (nFlag),
    .strobes  (strobes)
  );

  useq_datapath #(.PC_W(PC_W), .CTRL_W(CTRL_W), .OP_W(OP_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .extAddr   (extAddr),
    .opcode    (opcode),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobes   (strobes),
    .upc       (upcOut),
    .ctrlField (ctrlOut),
    .srcCode   (srcCode),
    .condBits  (condBits),
    .brAddr    (brAddr),
    .primed    (primed)
  );

endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
#(
  parameter int PC_W   = 9,
  parameter int CTRL_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   extAddr,
  input logic              zFlag,
  input logic              nFlag,
  input logic [PC_W-1:0]   upcOut,
  input logic [CTRL_W-1:0] ctrlOut,
  input logic              primed,
  input logic [SRC_W-1:0]  srcCode,
  input logic [COND_W-1:0] condBits,
  input logic [PC_W-1:0]   brAddr,
  input seqStrobe_t        strobes
);

  logic condOk;
  logic prevRst = 1'b0;
  logic [PC_W-1:0] prevExt = '0;

  assign condOk = condBits[0] | (condBits[1] & !zFlag) | (condBits[2] & zFlag)
                | (condBits[3] & !nFlag) | (condBits[4] & nFlag);

  always_ff @(posedge clk) begin
    prevRst <= rst;
    prevExt <= extAddr;
    if (prevRst) begin
      p_reset_load_r1: assert (upcOut == prevExt && ctrlOut == '0)
        else $error("reset state wrong");
    end
  end

  p_prime_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !primed |=> upcOut == $past(upcOut));

  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(strobes) == 1);

  p_inc_always_r4: assert property (@(posedge clk) disable iff (rst)
    (primed && srcCode == 2'b00) |=> upcOut == PC_W'($past(upcOut) + 1'b1));

  p_not_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (primed && !condOk) |=> upcOut == PC_W'($past(upcOut) + 1'b1));

  p_ext_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (primed && srcCode == 2'b10 && condOk) |=> upcOut == $past(extAddr));

  p_branch_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (primed && srcCode == 2'b11 && condOk) |=> upcOut == $past(brAddr));

endmodule

bind useq_top useq_checker #(.PC_W(PC_W), .CTRL_W(CTRL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .extAddr  (extAddr),
  .zFlag    (zFlag),
  .nFlag    (nFlag),
  .upcOut   (upcOut),
  .ctrlOut  (ctrlOut),
  .primed   (primed),
  .srcCode  (srcCode),
  .condBits (condBits),
  .brAddr   (brAddr),
  .strobes  (strobes)
);

// File: tb/tb_useq_top.sv
`timescale 1ns/1ps
module tb_useq_top;

  localparam int PC_W = 9;
  localparam int CTRL_W = 16;
  localparam int OP_W = 6;
  localparam int WORD_W = CTRL_W + PC_W + 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] extAddr = '0;
  logic [OP_W-1:0] opcode = '0;
  logic zFlag = 1'b0, nFlag = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0;
  logic [PC_W-1:0] wrAddr = '0;
  logic [WORD_W-1:0] wrData = '0;
  logic [CTRL_W-1:0] ctrlOut;
  logic [PC_W-1:0] upcOut;

  logic [WORD_W-1:0] shStore [1 << PC_W];
  logic [PC_W-1:0] shMap [1 << OP_W];
  logic [PC_W-1:0] curPc;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  useq_top dut (.*);

  function automatic logic [WORD_W-1:0] mkWord(input logic [CTRL_W-1:0] c,
      input logic [PC_W-1:0] b, input logic [4:0] cd, input logic [1:0] s);
    return {c, b, cd, s};
  endfunction

  function automatic logic [PC_W-1:0] nextOf(input logic [PC_W-1:0] pc,
      input logic [WORD_W-1:0] w, input logic z, input logic n,
      input logic [OP_W-1:0] op, input logic [PC_W-1:0] ext);
    logic [1:0] s;
    logic [4:0] cd;
    logic met;
    s = w[1:0];
    cd = w[6:2];
    met = cd[0] | (cd[1] & !z) | (cd[2] & z) | (cd[3] & !n) | (cd[4] & n);
    if (s == 2'b00 || !met) return pc + 1'b1;
    if (s == 2'b01) return shMap[op];
    if (s == 2'b10) return ext;
    return w[PC_W+6:7];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeStore(input logic [PC_W-1:0] a, input logic [WORD_W-1:0] d);
    @(negedge clk);
    wrEn = 1; wrSel = 0; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
    shStore[a] = d;
  endtask

  task automatic writeMap(input logic [OP_W-1:0] op, input logic [PC_W-1:0] a);
    @(negedge clk);
    wrEn = 1; wrSel = 1; wrAddr = PC_W'(op); wrData = WORD_W'(a);
    @(negedge clk);
    wrEn = 0;
    shMap[op] = a;
  endtask

  // assumes rst already high; applies ext, checks R1, releases, checks R2
  task automatic finishReset(input logic [PC_W-1:0] ext);
    @(negedge clk);
    extAddr = ext;
    @(negedge clk);
    check("R1 upc", upcOut, ext);
    check("R1 ctrl", ctrlOut, 0);
    rst = 0;
    @(negedge clk);
    check("R2 upc", upcOut, ext);
    check("R2,R3 ctrl", ctrlOut, shStore[ext][WORD_W-1:WORD_W-CTRL_W]);
    curPc = ext;
  endtask

  task automatic step(input logic z, input logic n, input logic [OP_W-1:0] op,
      input logic [PC_W-1:0] ext, input string tag);
    logic [PC_W-1:0] exp;
    zFlag = z; nFlag = n; opcode = op; extAddr = ext;
    exp = nextOf(curPc, shStore[curPc], z, n, op, ext);
    @(negedge clk);
    check(tag, upcOut, exp);
    check("R3 ctrl", ctrlOut, shStore[exp][WORD_W-1:WORD_W-CTRL_W]);
    curPc = exp;
  endtask

  initial begin
    rst = 1;
    for (int i = 0; i < (1 << PC_W); i++) writeStore(PC_W'(i), '0);
    for (int i = 0; i < (1 << OP_W); i++) writeMap(OP_W'(i), PC_W'(i * 7 + 3));

    // sweep: every src x condition mask x flag pair (R4..R7)
    for (int idx = 0; idx < 512; idx++) begin
      logic [PC_W-1:0] a, e, b, exp;
      logic [1:0] s;
      logic [4:0] cd;
      logic z, n;
      logic met;
      string tag;
      a = PC_W'(idx);
      s = idx[1:0]; cd = idx[6:2]; z = idx[7]; n = idx[8];
      e = a ^ 9'h155; b = a ^ 9'h0AA;
      rst = 1;
      writeStore(a, mkWord(CTRL_W'(idx * 3 + 1), b, cd, s));
      finishReset(a);
      zFlag = z; nFlag = n; opcode = OP_W'(idx); extAddr = e;
      exp = nextOf(a, shStore[a], z, n, OP_W'(idx), e);
      met = cd[0] | (cd[1] & !z) | (cd[2] & z) | (cd[3] & !n) | (cd[4] & n);
      tag = (s == 0) ? "R4" : (!met ? "R6,R7" : "R5,R7");
      @(negedge clk);
      check(tag, upcOut, exp);
    end

    // wrap at the top address (R8)
    rst = 1;
    writeStore(9'd511, mkWord(16'h00F0, 9'd3, 5'b11111, 2'b00));
    finishReset(9'd511);
    step(1, 1, 0, 9'd100, "R8");

    // example routine at 200..205
    rst = 1;
    writeStore(9'd200, mkWord(16'h0001, 0, 5'b00000, 2'b00));
    writeStore(9'd201, mkWord(16'h0002, 0, 5'b00001, 2'b01));
    writeStore(9'd202, mkWord(16'h0004, 0, 5'b00100, 2'b10));
    writeStore(9'd203, mkWord(16'h0008, 9'd300, 5'b10000, 2'b11));
    writeStore(9'd204, mkWord(16'h0000, 9'd206, 5'b01000, 2'b11));
    writeStore(9'd205, mkWord(16'h0020, 9'd204, 5'b00001, 2'b11));
    writeStore(9'd206, mkWord(16'h0040, 0, 5'b00000, 2'b00));
    writeStore(9'd300, mkWord(16'h0300, 0, 5'b00000, 2'b00));
    writeStore(9'd350, mkWord(16'h0350, 0, 5'b00000, 2'b00));
    writeMap(6'd5, 9'd202);

    // walk 1: dispatch via map, Z=0 falls through, N=1 branches
    finishReset(9'd200);
    step(0, 0, 5, 9'd200, "R4");
    step(0, 0, 5, 9'd200, "R9 map");
    step(0, 0, 5, 9'd200, "R6");
    step(0, 1, 5, 9'd200, "R5");
    check("R5 at 300", curPc, 300);

    // walk 2: Z=1 takes external address
    rst = 1;
    finishReset(9'd200);
    step(0, 0, 5, 9'd200, "R4");
    step(0, 0, 5, 9'd200, "R5");
    step(1, 0, 5, 9'd350, "R5 ext");
    check("R5 at 350", curPc, 350);

    // walk 3: while loop
    rst = 1;
    finishReset(9'd200);
    step(0, 0, 5, 9'd200, "R4");
    step(0, 0, 5, 9'd200, "R5");
    step(0, 0, 5, 9'd200, "R6");
    step(0, 0, 5, 9'd200, "R6");
    check("R10 enter", curPc, 204);
    step(0, 1, 5, 9'd200, "R10");
    step(0, 1, 5, 9'd200, "R10");
    step(0, 1, 5, 9'd200, "R10");
    step(0, 1, 5, 9'd200, "R10");
    check("R10 looped", curPc, 204);
    step(0, 0, 5, 9'd200, "R10");
    check("R10 exit", curPc, 206);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule